// File: doc/BRIEF.md
# TDM Multichannel Slot Selector

This block sequences the word slots of a serial time-division-multiplexed frame and, for each slot, tells the neighbouring serial shifter whether the slot's word takes part in the transfer and whether it must go through the companding unit. A channel counter is cleared by frame sync and steps forward on each slot strobe. It wraps after a programmable number of channels, anywhere from 1 to 128.

Two bitmap banks of four 32-bit words each are indexed by the current channel number. One bank marks the channels that carry data. The other marks the channels whose data is companded. A control word holds the channel count, the companding law (A-law or μ-law) and the port direction. The direction decides whether a companded slot is expanded, on receive, or compressed, on transmit.

All programming goes into shadow copies. The working copies are loaded only at frame sync, so a frame never sees a mix of old and new maps. The per-slot outputs are combinational from the registered counter and the working registers, so they are steady for the whole slot.

Top module: `tdm_slot_selector`

## Requirements
- R1: After reset the channel counter is 0, both bitmap banks and the control word read as 0 (one channel, A-law, transmit), and every per-slot output is low.
- R2: A frame sync clears the channel counter to 0 at the next clock edge. Frame sync takes priority over a slot strobe in the same cycle.
- R3: A slot strobe without frame sync advances the counter by one at the next edge. With neither strobe nor frame sync, the counter holds.
- R4: With count field N (control bits 6:0), the counter runs 0..N and a strobe at N returns it to 0, giving N+1 channels (1 to 128).
- R5: Addresses 0 to 3 hold the enable words. Bit n of the word at address k enables channel 32*k+n, and slot_active equals the working enable bit of the current channel.
- R6: Addresses 4 to 7 hold the compand words with the same bit-to-channel mapping. slot_compand is the current channel's compand bit AND slot_active.
- R7: Address 8 is the control word: bits 6:0 count field, bit 16 law (1 = μ-law, 0 = A-law), bit 17 direction (1 = receive). law_mulaw shows the working law bit. compand_expand equals slot_compand when the direction is receive, and compand_compress equals slot_compand when it is transmit.
- R8: Register writes change only the shadow copies. The working copies, and therefore every output, take the new values at the next frame sync edge. A write in the same cycle as frame sync waits for the following frame sync.
- R9: Writes to addresses 9 to 15 have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| frame_sync | input | 1 | Start of frame; clears counter and loads working registers |
| slot_strobe | input | 1 | Current slot serviced; advance counter |
| chan_idx | output | 7 | Current channel number |
| slot_active | output | 1 | Current slot word is transferred |
| slot_compand | output | 1 | Current slot word is companded |
| law_mulaw | output | 1 | 1 = μ-law, 0 = A-law |
| compand_expand | output | 1 | Companded slot on a receiving port |
| compand_compress | output | 1 | Companded slot on a transmitting port |

## Verification
The bench targets three kinds of error. The first is the wrap point. A counter that compares against N+1, or against the shadow count instead of the working one, would show a channel beyond the frame or wrap early after reprogramming. The count extremes N=0 and N=127 are driven, together with frame sync and strobe in the same cycle; a design that let the strobe win would leave the counter at 1.

The second is bit mapping. Channel 44 is placed in the second word. An off-by-one word select, or a compand bit that shows up on a disabled slot, would raise the wrong flag.

The third is shadowing. Writes are checked to stay invisible until frame sync, writes to unused addresses to change nothing, and random traffic mixes all of these.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
  // control word field positions (fixed, independent of channel count)
  localparam int CTL_LAW_BIT = 16;
  localparam int CTL_DIR_BIT = 17;
  // address regions, upper two address bits
  localparam logic [1:0] REG_ENABLE  = 2'b00;
  localparam logic [1:0] REG_COMPAND = 2'b01;
  localparam logic [1:0] REG_CONTROL = 2'b10;
endpackage

// File: rtl/tdm_bitmap_bank.sv
module tdm_bitmap_bank #(
  parameter int MAX_CH = 128,
  parameter int WORD_W = 32,
  localparam int NWORDS = MAX_CH / WORD_W,
  localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              load,
  output logic [MAX_CH-1:0] work_map
);
  logic [MAX_CH-1:0] shadow_map;

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_map[k*WORD_W +: WORD_W] <= '0;
        work_map[k*WORD_W +: WORD_W]   <= '0;
      end else begin
        if (wr_en && (wr_word == WSEL_W'(k)))
          shadow_map[k*WORD_W +: WORD_W] <= wr_data;
        if (load)
          work_map[k*WORD_W +: WORD_W] <= shadow_map[k*WORD_W +: WORD_W];
      end
    end
  end

  // R8
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(work_map));
  // R8
  map_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> work_map == $past(shadow_map));
endmodule

// File: rtl/tdm_ctl_reg.sv
module tdm_ctl_reg #(
  parameter int CNT_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [CNT_W-1:0]  last_ch,
  output logic              mulaw,
  output logic              rx_dir
);
  import tdm_sel_pkg::*;

  logic [CNT_W-1:0] sh_last;
  logic             sh_mulaw;
  logic             sh_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_last  <= '0;
      sh_mulaw <= 1'b0;
      sh_rx    <= 1'b0;
      last_ch  <= '0;
      mulaw    <= 1'b0;
      rx_dir   <= 1'b0;
    end else begin
      if (wr_en) begin
        sh_last  <= wr_data[CNT_W-1:0];
        sh_mulaw <= wr_data[CTL_LAW_BIT];
        sh_rx    <= wr_data[CTL_DIR_BIT];
      end
      if (load) begin
        last_ch <= sh_last;
        mulaw   <= sh_mulaw;
        rx_dir  <= sh_rx;
      end
    end
  end

  // R8
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({last_ch, mulaw, rx_dir}));
endmodule

// File: rtl/tdm_chan_counter.sv
module tdm_chan_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_sync,
  input  logic             slot_strobe,
  input  logic [CNT_W-1:0] last_ch,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (frame_sync)
      cnt <= '0;
    else if (slot_strobe)
      cnt <= (cnt == last_ch) ? '0 : cnt + 1'b1;
  end

  // R2
  fs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> cnt == '0);
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_strobe && !frame_sync && cnt != last_ch) |=> cnt == $past(cnt) + 1'b1);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!slot_strobe && !frame_sync) |=> $stable(cnt));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_strobe && !frame_sync && cnt == last_ch) |=> cnt == '0);
  // R4
  bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_ch);
endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode #(
  parameter int MAX_CH = 128,
  localparam int CNT_W = $clog2(MAX_CH)
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [MAX_CH-1:0] en_map,
  input  logic [MAX_CH-1:0] cp_map,
  input  logic              rx_dir,
  output logic              active,
  output logic              compand,
  output logic              expand,
  output logic              compress
);
  always_comb begin
    active   = en_map[cnt];
    compand  = active & cp_map[cnt];
    expand   = compand & rx_dir;
    compress = compand & ~rx_dir;
  end
endmodule

// File: rtl/tdm_slot_selector.sv
module tdm_slot_selector #(
  parameter int MAX_CH = 128,
  parameter int WORD_W = 32,
  localparam int NWORDS = MAX_CH / WORD_W,
  localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int ADDR_W = WSEL_W + 2,
  localparam int CNT_W  = $clog2(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              frame_sync,
  input  logic              slot_strobe,
  output logic [CNT_W-1:0]  chan_idx,
  output logic              slot_active,
  output logic              slot_compand,
  output logic              law_mulaw,
  output logic              compand_expand,
  output logic              compand_compress
);
  import tdm_sel_pkg::*;

  logic [1:0]        region;
  logic [WSEL_W-1:0] word_sel;
  logic              we_en, we_cp, we_ctl;
  logic [MAX_CH-1:0] en_map, cp_map;
  logic [CNT_W-1:0]  last_ch;
  logic              rx_dir;

  assign region   = wr_addr[ADDR_W-1 -: 2];
  assign word_sel = wr_addr[WSEL_W-1:0];
  assign we_en    = wr_en && (region == REG_ENABLE);
  assign we_cp    = wr_en && (region == REG_COMPAND);
  assign we_ctl   = wr_en && (region == REG_CONTROL) && (word_sel == '0);

  tdm_bitmap_bank #(.MAX_CH(MAX_CH), .WORD_W(WORD_W)) en_bank_i (
    .clk(clk), .rst(rst), .wr_en(we_en), .wr_word(word_sel),
    .wr_data(wr_data), .load(frame_sync), .work_map(en_map));

  tdm_bitmap_bank #(.MAX_CH(MAX_CH), .WORD_W(WORD_W)) cp_bank_i (
    .clk(clk), .rst(rst), .wr_en(we_cp), .wr_word(word_sel),
    .wr_data(wr_data), .load(frame_sync), .work_map(cp_map));

  tdm_ctl_reg #(.CNT_W(CNT_W), .DATA_W(WORD_W)) ctl_i (
    .clk(clk), .rst(rst), .wr_en(we_ctl), .wr_data(wr_data),
    .load(frame_sync), .last_ch(last_ch), .mulaw(law_mulaw), .rx_dir(rx_dir));

  tdm_chan_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .slot_strobe(slot_strobe),
    .last_ch(last_ch), .cnt(chan_idx));

  tdm_slot_decode #(.MAX_CH(MAX_CH)) dec_i (
    .cnt(chan_idx), .en_map(en_map), .cp_map(cp_map), .rx_dir(rx_dir),
    .active(slot_active), .compand(slot_compand),
    .expand(compand_expand), .compress(compand_compress));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (chan_idx == '0 && !slot_active && !law_mulaw));
endmodule

// File: tb/tdm_slot_selector_tb_top.sv
module tdm_slot_selector_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        frame_sync = 1'b0;
  logic        slot_strobe = 1'b0;
  logic [6:0]  chan_idx;
  logic        slot_active, slot_compand, law_mulaw, compand_expand, compand_compress;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [31:0] sh_en [4];
  logic [31:0] ac_en [4];
  logic [31:0] sh_cp [4];
  logic [31:0] ac_cp [4];
  logic [31:0] sh_ctl, ac_ctl;
  logic [6:0]  mcnt;

  always #4 clk = ~clk;

  tdm_slot_selector dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_sync(frame_sync), .slot_strobe(slot_strobe), .chan_idx(chan_idx),
    .slot_active(slot_active), .slot_compand(slot_compand), .law_mulaw(law_mulaw),
    .compand_expand(compand_expand), .compand_compress(compand_compress));

  function automatic logic [11:0] expected();
    logic a, c, rx;
    a  = ac_en[mcnt[6:5]][mcnt[4:0]];
    c  = a & ac_cp[mcnt[6:5]][mcnt[4:0]];
    rx = ac_ctl[17];
    return {mcnt, a, c, ac_ctl[16], c & rx, c & ~rx};
  endfunction

  task automatic check(input string tag);
    logic [11:0] act, exp;
    act = {chan_idx, slot_active, slot_compand, law_mulaw, compand_expand, compand_compress};
    exp = expected();
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%03h expected=%03h (chan %0d vs %0d)",
               tag, act, exp, act[11:5], exp[11:5]);
    end
  endtask

  // called at a falling edge: drive, take the rising edge, update model, check
  task automatic tick(input logic fs, input logic st, input logic we,
                      input logic [3:0] a, input logic [31:0] d, input string tag);
    frame_sync = fs; slot_strobe = st; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (fs) mcnt = '0;
    else if (st) mcnt = (mcnt == ac_ctl[6:0]) ? 7'd0 : mcnt + 7'd1;
    if (fs) begin
      for (int k = 0; k < 4; k++) begin ac_en[k] = sh_en[k]; ac_cp[k] = sh_cp[k]; end
      ac_ctl = sh_ctl;
    end
    if (we) begin
      if (a < 4) sh_en[a[1:0]] = d;
      else if (a < 8) sh_cp[a[1:0]] = d;
      else if (a == 8) sh_ctl = d & 32'h0003_007F;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    tick(1'b0, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic strobes(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b0, 4'd0, 32'd0, tag);
  endtask

  task automatic fsync(input string tag);
    tick(1'b1, 1'b0, 1'b0, 4'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin sh_en[k] = 0; ac_en[k] = 0; sh_cp[k] = 0; ac_cp[k] = 0; end
    sh_ctl = 0; ac_ctl = 0; mcnt = 0;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset");
    strobes(3, "R1 one channel after reset");

    // channel 44 = word 1 bit 12, receive, mu-law, 51 channels
    wr(4'd1, 32'h0000_1000, "R8 shadow enable");
    wr(4'd5, 32'h0000_1000, "R8 shadow compand");
    wr(4'd8, 32'h0003_0032, "R8 shadow control");
    strobes(2, "R8 not yet loaded");
    fsync("R8 load at frame sync");
    strobes(44, "R5 walk to channel 44");
    strobes(8, "R4 wrap at 50");

    // ignored addresses
    for (int a = 9; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF, "R9 unused address");
    fsync("R9 after frame sync");
    strobes(46, "R9 map unchanged");

    // frame sync wins over strobe; write in same cycle as frame sync waits
    tick(1'b1, 1'b1, 1'b1, 4'd0, 32'hFFFF_FFFF, "R2 fs with strobe");
    strobes(2, "R8 same-cycle write deferred");
    fsync("R2 clear");
    strobes(3, "R5 word0 enabled");

    // N = 0: single channel
    wr(4'd8, 32'h0000_0000, "R7 control");
    fsync("R4 N=0 load");
    strobes(4, "R4 N=0 stays at 0");

    // compand without enable, transmit A-law, 128 channels
    for (int k = 0; k < 4; k++) wr(4'(k), 32'hA5A5_0F0F, "R6 enable words");
    for (int k = 0; k < 4; k++) wr(4'(4 + k), 32'hFFFF_0000, "R6 compand words");
    wr(4'd8, 32'h0000_007F, "R7 transmit A-law");
    fsync("R7 load");
    strobes(130, "R6 compand gated by enable, R4 N=127 wrap");
    wr(4'd8, 32'h0002_007F, "R7 receive");
    fsync("R7 receive load");
    strobes(40, "R7 expand on receive");

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      logic fs, st, we;
      logic [3:0] a;
      logic [31:0] d;
      fs = ($urandom % 60) == 0;
      st = ($urandom % 3) != 0;
      we = ($urandom % 12) == 0;
      a  = 4'($urandom % 16);
      d  = $urandom;
      if (a == 4'd8) d[6:0] = ($urandom % 2) ? 7'($urandom % 8) : d[6:0];
      tick(fs, st, we, a, d, "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule